// File: doc/BRIEF.md
# Control Endpoint Receive Handshake Controller

This block decides, for the control endpoint of a low-speed (1.5 Mb/s) USB function, what happens to each incoming data packet. The serial engine in front of it has already done NRZI decoding, bit unstuffing and CRC checking. It delivers single-cycle token strobes for SETUP and OUT, one strobe per received data byte, and an end-of-packet strobe that carries a CRC-good flag. The block decides whether each byte goes into an 8-byte endpoint buffer. It also decides whether the packet is answered with ACK, with NAK, or not at all.

Two firmware-visible control bits steer the decision. The receive-enable bit arms the endpoint for one OUT packet. The write-inhibit bit freezes the buffer until the next SETUP. Hardware clears these bits on its own. A SETUP token clears both. An OUT packet that is answered with ACK clears receive-enable at its handshake, and not at its token. A NAKed OUT leaves both bits untouched. SETUP data is always taken and acknowledged. Firmware reads the buffer through a combinational read port, and a byte-count register holds the length of the last accepted packet. An interrupt pulse is raised for each SETUP and for each OUT answered with ACK.

Top module: `ep0_out_ctrl`

## Requirements
- R1: After an OUT token with receive-enable 1 and inhibit 0, each data byte is stored at buffer addresses 0, 1, 2, ... in order. A good-CRC end of packet then gives a one-cycle `hs_ack_o` in the cycle after the end-of-packet strobe, and `byte_cnt_o` becomes the number of bytes stored.
- R2: After an OUT token with receive-enable 0, no byte is stored. A good-CRC end of packet gives a one-cycle `hs_nak_o` in the cycle after the strobe, and `byte_cnt_o` keeps its previous value.
- R3: A SETUP token clears receive-enable and inhibit. Both read 0 in the cycle after the token.
- R4: An OUT answered with ACK clears receive-enable in the cycle after its end-of-packet strobe. Receive-enable stays 1 from the token through the whole data phase.
- R5: An OUT answered with NAK leaves receive-enable and inhibit unchanged.
- R6: While inhibit is 1, OUT data is not stored and the packet is answered with NAK. Inhibit stays 1 until a SETUP token or a firmware write clears it.
- R7: A SETUP data packet with good CRC is always stored and answered with ACK, whatever the control bits were before the token.
- R8: An end of packet with bad CRC gives no handshake and no interrupt, and leaves both control bits and `byte_cnt_o` unchanged.
- R9: The buffer holds 8 bytes. In an accepted packet, bytes after the eighth are dropped, the first eight are kept, and `byte_cnt_o` saturates at 8.
- R10: A cycle with `cfg_we_i` high loads `cfg_rx_en_i` and `cfg_inhibit_i` into the bits, visible in the next cycle. A hardware clear in the same cycle (SETUP token, or the end-of-packet strobe of an OUT that is answered with ACK) wins over the firmware value of the bit it clears.
- R11: `irq_o` pulses for exactly one cycle, together with `hs_ack_o`. It does not pulse on a NAK.
- R12: After reset both control bits are 0, `byte_cnt_o` is 0 and no handshake is signalled. A new token in the middle of a packet abandons that packet and restarts storage at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tok_setup_i | input | 1 | SETUP token received for the endpoint (single-cycle strobe) |
| tok_out_i | input | 1 | OUT token received for the endpoint (single-cycle strobe) |
| byte_vld_i | input | 1 | A data byte is present on `byte_i` |
| byte_i | input | 8 | Received data byte |
| eop_i | input | 1 | End of data packet (single-cycle strobe) |
| crc_ok_i | input | 1 | Packet CRC was good; sampled together with `eop_i` |
| cfg_we_i | input | 1 | Firmware write of the control bits |
| cfg_rx_en_i | input | 1 | Receive-enable value to write |
| cfg_inhibit_i | input | 1 | Write-inhibit value to write |
| rd_addr_i | input | 3 | Buffer read address |
| rd_data_o | output | 8 | Buffer byte at `rd_addr_i` (combinational) |
| rx_en_o | output | 1 | Current receive-enable bit |
| inhibit_o | output | 1 | Current write-inhibit bit |
| hs_ack_o | output | 1 | Return ACK (single-cycle pulse) |
| hs_nak_o | output | 1 | Return NAK (single-cycle pulse) |
| byte_cnt_o | output | 4 | Byte count of the last accepted packet |
| irq_o | output | 1 | Transfer-complete interrupt pulse |

## Verification
The bench sweeps OUT packets of 0 to 10 bytes over every combination of the two control bits and the CRC flag. It also sweeps SETUP packets over every preset of the bits. A design that cleared receive-enable at the OUT token, or on a NAK, would show the wrong bit either in the middle of the packet or after the handshake. A design that stored past eight bytes would corrupt the count or wrap around and overwrite address 0. The bench drives firmware writes in the same cycle as a SETUP token, and in the same cycle as the end of an ACKed OUT. A design that let the firmware set win would leave receive-enable at 1. It also checks that a packet with a bad CRC produces no handshake and keeps the old count. A restarted packet must begin storing again at address 0.

// File: rtl/ep0_out_pkg.sv
package ep0_out_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_OUT} phase_e;
endpackage

// File: rtl/ep0_ctl_regs.sv
module ep0_ctl_regs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fw_we_i,
  input  logic fw_rx_en_i,
  input  logic fw_inh_i,
  input  logic setup_clr_i,
  input  logic ack_clr_i,
  output logic rx_en_o,
  output logic inh_o
);
  logic rx_en_q, inh_q;

  // hardware clears take priority over firmware writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_q <= 1'b0;
      inh_q   <= 1'b0;
    end else begin
      if (setup_clr_i || ack_clr_i) rx_en_q <= 1'b0;
      else if (fw_we_i)             rx_en_q <= fw_rx_en_i;
      if (setup_clr_i)              inh_q   <= 1'b0;
      else if (fw_we_i)             inh_q   <= fw_inh_i;
    end
  end

  assign rx_en_o = rx_en_q;
  assign inh_o   = inh_q;
endmodule

// File: rtl/ep0_fifo_mem.sv
module ep0_fifo_mem #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/ep0_rx_fsm.sv
module ep0_rx_fsm
  import ep0_out_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tok_setup_i,
  input  logic          tok_out_i,
  input  logic          byte_vld_i,
  input  logic [DW-1:0] byte_i,
  input  logic          eop_i,
  input  logic          crc_ok_i,
  input  logic          rx_en_i,
  input  logic          inh_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          ack_clr_o,
  output logic          hs_ack_o,
  output logic          hs_nak_o,
  output logic          irq_o,
  output logic [CW-1:0] byte_cnt_o
);
  phase_e        ph_q;
  logic          acc_q;
  logic [CW-1:0] ptr_q, cnt_q;
  logic          ack_q, nak_q, irq_q;
  logic          tok_any, eop_live, room;

  assign tok_any  = tok_setup_i | tok_out_i;
  assign eop_live = eop_i && !tok_any && (ph_q != PH_IDLE);
  assign room     = ptr_q < CW'(DEPTH);

  assign wr_en_o   = (ph_q != PH_IDLE) && acc_q && byte_vld_i && !eop_i && !tok_any && room;
  assign wr_addr_o = ptr_q[AW-1:0];
  assign wr_data_o = byte_i;
  assign ack_clr_o = eop_live && crc_ok_i && acc_q && (ph_q == PH_OUT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      acc_q <= 1'b0;
      ptr_q <= '0;
      cnt_q <= '0;
      ack_q <= 1'b0;
      nak_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      nak_q <= 1'b0;
      irq_q <= 1'b0;
      if (tok_setup_i) begin
        ph_q  <= PH_SETUP;
        acc_q <= 1'b1;
        ptr_q <= '0;
      end else if (tok_out_i) begin
        ph_q  <= PH_OUT;
        acc_q <= rx_en_i && !inh_i;
        ptr_q <= '0;
      end else if (eop_live) begin
        ph_q <= PH_IDLE;
        if (crc_ok_i) begin
          if (acc_q) begin
            ack_q <= 1'b1;
            irq_q <= 1'b1;
            cnt_q <= ptr_q;
          end else begin
            nak_q <= 1'b1;
          end
        end
      end else if (wr_en_o) begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  assign hs_ack_o   = ack_q;
  assign hs_nak_o   = nak_q;
  assign irq_o      = irq_q;
  assign byte_cnt_o = cnt_q;

  assert_nak_when_disabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eop_i && crc_ok_i && !tok_any && ph_q == PH_OUT && !acc_q) |=> (hs_nak_o && !hs_ack_o));
  assert_ack_clears_rx_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_clr_o |=> !rx_en_i);
  assert_bad_crc_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eop_i && !crc_ok_i) |=> (!hs_ack_o && !hs_nak_o && !irq_o));
  assert_cnt_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_cnt_o <= CW'(DEPTH));
  assert_irq_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  assert_ack_nak_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_ack_o && hs_nak_o));
endmodule

// File: rtl/ep0_out_ctrl.sv
module ep0_out_ctrl #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tok_setup_i,
  input  logic          tok_out_i,
  input  logic          byte_vld_i,
  input  logic [DW-1:0] byte_i,
  input  logic          eop_i,
  input  logic          crc_ok_i,
  input  logic          cfg_we_i,
  input  logic          cfg_rx_en_i,
  input  logic          cfg_inhibit_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rx_en_o,
  output logic          inhibit_o,
  output logic          hs_ack_o,
  output logic          hs_nak_o,
  output logic [CW-1:0] byte_cnt_o,
  output logic          irq_o
);
  logic          wr_en, ack_clr;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  ep0_ctl_regs u_regs (
    .clk_i, .rst_ni,
    .fw_we_i     (cfg_we_i),
    .fw_rx_en_i  (cfg_rx_en_i),
    .fw_inh_i    (cfg_inhibit_i),
    .setup_clr_i (tok_setup_i),
    .ack_clr_i   (ack_clr),
    .rx_en_o     (rx_en_o),
    .inh_o       (inhibit_o)
  );

  ep0_rx_fsm #(.DEPTH(DEPTH), .DW(DW)) u_fsm (
    .clk_i, .rst_ni,
    .tok_setup_i, .tok_out_i, .byte_vld_i, .byte_i, .eop_i, .crc_ok_i,
    .rx_en_i    (rx_en_o),
    .inh_i      (inhibit_o),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .ack_clr_o  (ack_clr),
    .hs_ack_o, .hs_nak_o, .irq_o, .byte_cnt_o
  );

  ep0_fifo_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i,
    .rd_data_o
  );

  assert_setup_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_setup_i |=> (!rx_en_o && !inhibit_o));
  assert_nak_keeps_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_nak_o && !$past(cfg_we_i)) |-> (rx_en_o == $past(rx_en_o) && inhibit_o == $past(inhibit_o)));
  assert_irq_with_ack_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == hs_ack_o);
endmodule

// File: tb/ep0_out_ctrl_bench.sv
module ep0_out_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tok_setup = 1'b0, tok_out = 1'b0, byte_vld = 1'b0, eop = 1'b0, crc_ok = 1'b0;
  logic [7:0] byte_d = '0;
  logic       cfg_we = 1'b0, cfg_rx = 1'b0, cfg_inh = 1'b0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       rx_en, inh, ack, nak, irq;
  logic [3:0] cnt;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  logic [7:0] exp_mem [8];

  always #10 clk = ~clk;

  ep0_out_ctrl u_ep0_out_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .tok_setup_i(tok_setup), .tok_out_i(tok_out), .byte_vld_i(byte_vld), .byte_i(byte_d),
    .eop_i(eop), .crc_ok_i(crc_ok),
    .cfg_we_i(cfg_we), .cfg_rx_en_i(cfg_rx), .cfg_inhibit_i(cfg_inh),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .rx_en_o(rx_en), .inhibit_o(inh), .hs_ack_o(ack), .hs_nak_o(nak),
    .byte_cnt_o(cnt), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fw_write(input logic r, input logic i);
    cfg_we = 1'b1; cfg_rx = r; cfg_inh = i;
    tick();
    cfg_we = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic send_bytes(input int seed, input int n, input bit store);
    for (int i = 0; i < n; i++) begin
      byte_vld = 1'b1; byte_d = pat(seed, i);
      if (store && i < 8) exp_mem[i] = pat(seed, i);
      tick();
    end
    byte_vld = 1'b0;
  endtask

  task automatic end_pkt(input logic c);
    eop = 1'b1; crc_ok = c;
    tick();
    eop = 1'b0; crc_ok = 1'b0;
  endtask

  task automatic check_mem(input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      rd_addr = 3'(k);
      #1;
      chk(tag, int'(rd_data), int'(exp_mem[k]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 rx_en reset", rx_en, 0);
    chk("R12 inhibit reset", inh, 0);
    chk("R12 count reset", cnt, 0);
    chk("R12 no ack reset", ack, 0);
    chk("R12 no nak reset", nak, 0);

    // R10 plain firmware writes
    fw_write(1'b1, 1'b1);
    chk("R10 write rx_en", rx_en, 1);
    chk("R10 write inhibit", inh, 1);
    fw_write(1'b0, 1'b0);
    chk("R10 clear rx_en", rx_en, 0);
    chk("R10 clear inhibit", inh, 0);

    // OUT sweep: R1 R2 R4 R5 R6 R8 R9 R11
    for (int r = 0; r < 2; r++)
      for (int ib = 0; ib < 2; ib++)
        for (int c = 0; c < 2; c++)
          for (int n = 0; n <= 10; n++) begin
            bit acc;
            int stored;
            acc = (r == 1) && (ib == 0);
            stored = (n > 8) ? 8 : n;
            seed++;
            fw_write(1'(r), 1'(ib));
            tok_out = 1'b1; tick(); tok_out = 1'b0;
            send_bytes(seed, n, acc && c == 1);
            chk("R4 rx_en held in data phase", rx_en, r);
            end_pkt(1'(c));
            if (c == 1) begin
              chk(acc ? "R1 ack" : "R2 R6 nak", ack, int'(acc));
              chk(acc ? "R1 no nak" : "R2 R6 nak asserted", nak, int'(!acc));
              chk("R11 irq with ack", irq, int'(acc));
              chk(acc ? "R4 rx_en cleared" : "R5 rx_en kept", rx_en, acc ? 0 : r);
              chk(acc ? "R4 inhibit kept" : "R5 R6 inhibit kept", inh, ib);
              if (acc) exp_cnt = stored;
              chk(acc ? "R1 R9 count" : "R2 count kept", cnt, exp_cnt);
              if (acc) check_mem("R1 R9 buffer data", stored);
            end else begin
              chk("R8 no ack", ack, 0);
              chk("R8 no nak", nak, 0);
              chk("R8 no irq", irq, 0);
              chk("R8 rx_en kept", rx_en, r);
              chk("R8 inhibit kept", inh, ib);
              chk("R8 count kept", cnt, exp_cnt);
            end
            tick();
            chk("R11 ack single cycle", ack, 0);
            chk("R11 irq single cycle", irq, 0);
          end

    // SETUP sweep: R3 R7 R8 R9
    for (int pre = 0; pre < 4; pre++)
      for (int c = 0; c < 2; c++)
        for (int n = 0; n <= 9; n++) begin
          seed++;
          fw_write(1'(pre & 1), 1'(pre >> 1));
          tok_setup = 1'b1; tick(); tok_setup = 1'b0;
          chk("R3 setup clears rx_en", rx_en, 0);
          chk("R3 setup clears inhibit", inh, 0);
          send_bytes(seed, n, c == 1);
          end_pkt(1'(c));
          chk(c == 1 ? "R7 setup ack" : "R8 setup no ack", ack, c);
          chk("R7 setup no nak", nak, 0);
          chk(c == 1 ? "R11 setup irq" : "R8 setup no irq", irq, c);
          if (c == 1) exp_cnt = (n > 8) ? 8 : n;
          chk(c == 1 ? "R7 R9 setup count" : "R8 setup count kept", cnt, exp_cnt);
          if (c == 1) check_mem("R7 setup buffer data", exp_cnt);
          tick();
        end

    // R10 firmware set collides with SETUP token
    cfg_we = 1'b1; cfg_rx = 1'b1; cfg_inh = 1'b1; tok_setup = 1'b1;
    tick();
    cfg_we = 1'b0; tok_setup = 1'b0;
    chk("R10 setup beats fw rx_en", rx_en, 0);
    chk("R10 setup beats fw inhibit", inh, 0);
    end_pkt(1'b1);
    exp_cnt = 0;
    chk("R7 empty setup ack", ack, 1);
    tick();

    // R10 firmware set collides with end of ACKed OUT
    fw_write(1'b1, 1'b0);
    tok_out = 1'b1; tick(); tok_out = 1'b0;
    seed++;
    send_bytes(seed, 2, 1'b1);
    eop = 1'b1; crc_ok = 1'b1; cfg_we = 1'b1; cfg_rx = 1'b1; cfg_inh = 1'b1;
    tick();
    eop = 1'b0; crc_ok = 1'b0; cfg_we = 1'b0;
    chk("R10 ack clear beats fw rx_en", rx_en, 0);
    chk("R10 fw inhibit applied", inh, 1);
    chk("R10 ack on collision", ack, 1);
    exp_cnt = 2;
    chk("R1 count on collision", cnt, 2);
    tick();

    // R12 token mid packet restarts storage
    fw_write(1'b1, 1'b0);
    tok_out = 1'b1; tick(); tok_out = 1'b0;
    seed++;
    send_bytes(seed, 3, 1'b0);
    tok_setup = 1'b1; tick(); tok_setup = 1'b0;
    seed++;
    send_bytes(seed, 2, 1'b1);
    end_pkt(1'b1);
    chk("R12 restarted ack", ack, 1);
    chk("R12 restarted count", cnt, 2);
    check_mem("R12 restart from address 0", 2);
    tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule